// File: doc/BRIEF.md
# Smart-Card Character Receiver

This block receives asynchronous characters on one serial line of a half-duplex smart-card link. The width of one bit, in system clocks, comes from a programmable divider input. After a falling edge on the idle-high line, the receiver checks that the line is still low in the middle of the start bit. It then samples eight data bits, least significant first, and one parity bit, each at the middle of its bit. It checks one or two stop bits and measures the time to the next start edge. A completed byte appears on a parallel output together with three sticky status flags: byte ready, overrun and frame error. One acknowledge input clears all three flags.

The control is a four-state machine. IDLE moves to PEND on a synchronized falling edge. PEND returns to IDLE if the line goes back high before mid-start, and moves to SHIFT at mid-start. SHIFT takes eight data samples and moves to TAIL when it samples the parity bit. TAIL either moves to PEND on a new falling edge (back-to-back character) or moves to IDLE three cycles before the nominal end of the frame. `start_pend` is high in PEND. `busy` is high in SHIFT and TAIL.

Top module: `sccr_rx`

## Requirements
- R1: One bit lasts P = `bit_div` + 1 clock cycles. `bit_div` must be at least 7.
- R2: A character is one low start bit, 8 data bits least significant first, one parity bit and the stop bit(s). `rx_data` shows the 8 data bits. Let edge k be the first rising clock edge at which `line_in` is low. `rx_ready` rises exactly 9*P + floor(P/2) + 3 cycles after edge k.
- R3: With `PAR_POL` = 1, the parity bit must equal the XOR of the 8 data bits. With `PAR_POL` = 0, it must equal the inverse of that XOR. A correct parity bit raises no error flag.
- R4: A parity mismatch raises `rx_frame_err`. It leaves `rx_ready` and `rx_data` unchanged.
- R5: A character that completes while `rx_ready` is set and `ack` is low raises `rx_overrun`. `rx_data` keeps the earlier byte and `rx_ready` stays set.
- R6: A one-cycle `ack` pulse clears `rx_ready`, `rx_overrun` and `rx_frame_err`. If a flag is set and cleared in the same cycle, the set wins. With `ack` held high through a whole character, `rx_ready` or `rx_frame_err` is still high for one cycle and the byte is still loaded.
- R7: A low pulse on `line_in` of at most floor(P/2) cycles raises `start_pend` and then returns to idle. It does not raise `busy`, does not change any flag and does not change `rx_data`.
- R8: `start_pend` and `busy` are never high at the same time.
- R9: A stop bit sampled low raises `rx_frame_err`. `two_stop` = 1 expects two stop bits, giving a frame of E = 12*P cycles. Otherwise E = 11*P.
- R10: With no further start, `busy` falls exactly E cycles after edge k.
- R11: A next start whose edge k' comes fewer than E - floor(P/4) cycles after edge k raises `rx_frame_err`. A start at or after that limit raises no error. In both cases the new character is received, and `busy` drops low between the two characters.
- R12: An active-low asynchronous `rst_n` returns the block to IDLE with all flags low and `rx_data` zero, even in the middle of a character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_in | input | 1 | Serial line, idle high |
| bit_div | input | 13 | Bit period minus one, in clocks |
| two_stop | input | 1 | 1 selects two stop bits |
| ack | input | 1 | Clears the three sticky flags |
| rx_data | output | 8 | Last accepted byte |
| rx_ready | output | 1 | New byte available |
| rx_overrun | output | 1 | Byte completed while the previous one was unread |
| rx_frame_err | output | 1 | Parity, stop-bit or early-start error |
| start_pend | output | 1 | Falling edge seen, start not yet confirmed |
| busy | output | 1 | Reception confirmed and in progress |

## Verification
The sample point lives in the machine's internal counters. If the state or sample counter is wrong, `rx_ready` rises on a cycle other than the exact one given in R2, or the assembled byte differs in `rx_data`, about ten bit periods after the start edge. A wrong end-of-frame count shows as a `busy` fall away from E cycles after the edge, or as a flagged or missed early start in the next character. A lost PEND abandonment shows within one frame as a spurious `busy` rise after a glitch.

// File: rtl/sccr_pkg.sv
`timescale 1ns/1ps
package sccr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PEND  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_TAIL  = 2'd3
    } rx_state_t;
endpackage

// File: rtl/sccr_sync.sv
`timescale 1ns/1ps
module sccr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_s,
    output logic fall
);
    // STAGES synchronizer flops plus one history flop for edge detection
    logic [STAGES:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-1:0], line_in};
    end

    assign line_s = chain[STAGES-1];
    assign fall   = chain[STAGES] & ~chain[STAGES-1];
endmodule

// File: rtl/sccr_bit_timer.sv
`timescale 1ns/1ps
module sccr_bit_timer #(
    parameter int DIV_W   = 13,
    parameter int MIN_DIV = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DIV_W-1:0] bit_div,
    input  logic             two_stop,
    output logic             hit,
    output logic             at_end,
    output logic             too_early
);
    localparam int CW = DIV_W + 5;

    logic [CW-1:0] period, half, quarter, frame_len;
    logic [CW-1:0] elapsed, next_pt;

    assign period    = {5'd0, bit_div} + CW'(1);
    assign half      = period >> 1;
    assign quarter   = period >> 2;
    assign frame_len = two_stop ? ((period << 3) + (period << 2))
                                : ((period << 3) + (period << 1) + period);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            elapsed <= '0;
            next_pt <= '0;
        end else if (restart) begin
            elapsed <= '0;
            next_pt <= half;
        end else begin
            if (elapsed != '1) elapsed <= elapsed + CW'(1);
            if (hit)           next_pt <= next_pt + period;
        end
    end

    assign hit       = (elapsed == next_pt);
    assign at_end    = (elapsed == frame_len - CW'(3));
    assign too_early = (elapsed < frame_len - quarter - CW'(1));

    // R1: the divider must leave room for a sample point and the end margin
    assert_div_floor_R1: assert property (@(posedge clk) disable iff (!rst_n)
        restart |-> (bit_div >= DIV_W'(MIN_DIV)));

    // R2: sample points are a whole bit apart, never on adjacent cycles
    assert_hit_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !restart) |=> !hit);
endmodule

// File: rtl/sccr_rx.sv
`timescale 1ns/1ps
module sccr_rx #(
    parameter int   DIV_W       = 13,
    parameter int   DATA_W      = 8,
    parameter int   SYNC_STAGES = 2,
    parameter logic PAR_POL     = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_in,
    input  logic [DIV_W-1:0]  bit_div,
    input  logic              two_stop,
    input  logic              ack,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              rx_overrun,
    output logic              rx_frame_err,
    output logic              start_pend,
    output logic              busy
);
    import sccr_pkg::*;

    localparam int IDX_W = $clog2(DATA_W + 1);

    rx_state_t         state, state_nx;
    logic              line_s, fall;
    logic              hit, at_end, too_early, restart;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] shreg;
    logic              take_bit, par_evt, par_good, stop_bad, early_evt, load_ok;

    sccr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .line_in(line_in),
        .line_s(line_s), .fall(fall)
    );

    sccr_bit_timer #(.DIV_W(DIV_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .bit_div(bit_div), .two_stop(two_stop),
        .hit(hit), .at_end(at_end), .too_early(too_early)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        restart  = 1'b0;
        unique case (state)
            ST_IDLE: if (fall) begin
                state_nx = ST_PEND;
                restart  = 1'b1;
            end
            ST_PEND: begin
                if (line_s)   state_nx = ST_IDLE;
                else if (hit) state_nx = ST_SHIFT;
            end
            ST_SHIFT: if (hit && idx == IDX_W'(DATA_W)) state_nx = ST_TAIL;
            ST_TAIL: begin
                if (fall) begin
                    state_nx = ST_PEND;
                    restart  = 1'b1;
                end else if (at_end) begin
                    state_nx = ST_IDLE;
                end
            end
        endcase
    end

    // status outputs
    always_comb begin
        start_pend = (state == ST_PEND);
        busy       = (state == ST_SHIFT) || (state == ST_TAIL);
    end

    assign take_bit  = (state == ST_SHIFT) && hit && (idx < IDX_W'(DATA_W));
    assign par_evt   = (state == ST_SHIFT) && hit && (idx == IDX_W'(DATA_W));
    assign par_good  = (^shreg) ^ line_s ^ PAR_POL;
    assign stop_bad  = (state == ST_TAIL) && hit && !line_s;
    assign early_evt = (state == ST_TAIL) && fall && too_early;
    assign load_ok   = par_evt && par_good;

    // datapath and sticky flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx          <= '0;
            shreg        <= '0;
            rx_data      <= '0;
            rx_ready     <= 1'b0;
            rx_overrun   <= 1'b0;
            rx_frame_err <= 1'b0;
        end else begin
            if (state == ST_PEND) idx <= '0;
            else if (take_bit)    idx <= idx + IDX_W'(1);

            if (take_bit) shreg <= {line_s, shreg[DATA_W-1:1]};

            if (load_ok && (!rx_ready || ack)) rx_data <= shreg;

            if (load_ok)  rx_ready <= 1'b1;
            else if (ack) rx_ready <= 1'b0;

            if (load_ok && rx_ready && !ack) rx_overrun <= 1'b1;
            else if (ack)                    rx_overrun <= 1'b0;

            if ((par_evt && !par_good) || stop_bad || early_evt) rx_frame_err <= 1'b1;
            else if (ack)                                        rx_frame_err <= 1'b0;
        end
    end

    // R2: a byte only becomes ready as the machine enters the tail of a frame
    assert_ready_in_tail_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ready) |-> busy);

    // R5: an overrun is only reported while the earlier byte is still pending
    assert_overrun_keeps_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_overrun) |-> rx_ready);

    // R5: the data output never changes without a ready byte
    assert_data_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_data) |-> rx_ready);

    // R6: acknowledge while idle leaves every flag clear
    assert_ack_idle_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && state == ST_IDLE) |=> !(rx_ready || rx_overrun || rx_frame_err));
endmodule

// File: tb/test_sccr_rx.sv
`timescale 1ns/1ps
module test_sccr_rx;
    localparam int   DIV = 15;
    localparam int   P   = DIV + 1;
    localparam int   H   = P / 2;
    localparam int   Q   = P / 4;
    localparam logic POL = 1'b1;

    logic        clk = 1'b0, rst_n = 1'b0, line_in = 1'b1, two_stop = 1'b0, ack = 1'b0;
    logic [12:0] bit_div = 13'(DIV);
    logic [7:0]  rx_data;
    logic        rx_ready, rx_overrun, rx_frame_err, start_pend, busy;

    sccr_rx #(.PAR_POL(POL)) i_sccr_rx (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .bit_div(bit_div),
        .two_stop(two_stop), .ack(ack), .rx_data(rx_data), .rx_ready(rx_ready),
        .rx_overrun(rx_overrun), .rx_frame_err(rx_frame_err),
        .start_pend(start_pend), .busy(busy)
    );

    always #2 clk = ~clk;   // 250 MHz

    int cyc = 0, checks = 0, errors = 0;
    int last_k = 0, rdy_lat = -1, busy_lat = -1;
    int rdy_rises = 0, ferr_rises = 0, busy_rises = 0, pend_rises = 0, both_high = 0;
    logic prev_rdy = 1'b0, prev_busy = 1'b0, prev_pend = 1'b0, prev_ferr = 1'b0;
    bit done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_ready && !prev_rdy)     begin rdy_rises++; rdy_lat = cyc - last_k; end
            if (!busy && prev_busy)        busy_lat = cyc - last_k;
            if (busy && !prev_busy)        busy_rises++;
            if (start_pend && !prev_pend)  pend_rises++;
            if (rx_frame_err && !prev_ferr) ferr_rises++;
            if (start_pend && busy)        both_high++;
        end
        prev_rdy  = rx_ready;
        prev_busy = busy;
        prev_pend = start_pend;
        prev_ferr = rx_frame_err;
    end

    function automatic logic par_bit(input logic [7:0] d);
        return (^d) ^ ~POL;
    endfunction
    function automatic int exp_lat();
        return 9 * P + H + 3;
    endfunction
    function automatic int exp_end(input logic two);
        return two ? 12 * P : 11 * P;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_ack();
        ack = 1'b1; hold(1); ack = 1'b0;
    endtask

    // called at a negedge; returns at a negedge
    task automatic send_char(input logic [7:0] d, input bit bad_par,
                             input int stop_len, input logic stop_val);
        line_in = 1'b0; last_k = cyc + 1; hold(P);
        for (int i = 0; i < 8; i++) begin line_in = d[i]; hold(P); end
        line_in = bad_par ? ~par_bit(d) : par_bit(d); hold(P);
        line_in = stop_val; hold(stop_len);
        line_in = 1'b1;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] d, prev_d, a, b;
        int r0, b0, p0;
        void'($urandom(32'd20240611));
        hold(4);
        chk("R12 reset ready", rx_ready, 0);
        chk("R12 reset flags", {rx_overrun, rx_frame_err, start_pend, busy}, 0);
        chk("R12 reset data", rx_data, 0);
        rst_n = 1'b1; hold(5);

        // random characters, random stop count and gaps
        prev_d = 8'h00;
        for (int n = 0; n < 14; n++) begin
            logic two;
            d   = 8'($urandom);
            two = 1'($urandom);
            two_stop = two;
            hold(2);
            send_char(d, 1'b0, two ? 2 * P : P, 1'b1);
            hold(4);
            chk("R2 data", rx_data, d);
            chk("R2 ready latency", rdy_lat, exp_lat());
            chk("R3 no error on good parity", {rx_overrun, rx_frame_err}, 0);
            chk("R10 busy fall", busy_lat, exp_end(two));
            chk("R9 stop count frame length", rx_ready, 1);
            pulse_ack();
            chk("R6 ack clears ready", rx_ready, 0);
            hold(3 + ($urandom % 20));
            prev_d = d;
        end
        two_stop = 1'b0;

        // parity mismatch
        send_char(8'h5A, 1'b1, P, 1'b1); hold(4);
        chk("R4 parity error flag", rx_frame_err, 1);
        chk("R4 ready untouched", rx_ready, 0);
        chk("R4 data untouched", rx_data, prev_d);
        pulse_ack();
        chk("R6 ack clears frame error", rx_frame_err, 0);

        // overrun
        send_char(8'hA1, 1'b0, P, 1'b1); hold(5);
        send_char(8'h3C, 1'b0, P, 1'b1); hold(5);
        chk("R5 overrun flag", rx_overrun, 1);
        chk("R5 ready stays", rx_ready, 1);
        chk("R5 data keeps first", rx_data, 8'hA1);
        pulse_ack();
        chk("R6 ack clears all", {rx_ready, rx_overrun, rx_frame_err}, 0);

        // acknowledge held high through a reception
        ack = 1'b1; r0 = rdy_rises; hold(2);
        send_char(8'hC7, 1'b0, P, 1'b1); hold(4);
        chk("R6 ready visible under held ack", rdy_rises, r0 + 1);
        chk("R6 byte loaded under held ack", rx_data, 8'hC7);
        chk("R6 ready cleared by held ack", rx_ready, 0);
        r0 = ferr_rises;
        send_char(8'h19, 1'b1, P, 1'b1); hold(4);
        chk("R6 frame error visible under held ack", ferr_rises, r0 + 1);
        ack = 1'b0; hold(3);

        // start glitch
        b0 = busy_rises; p0 = pend_rises;
        line_in = 1'b0; hold(H); line_in = 1'b1; hold(40);
        chk("R7 glitch raises pending start", pend_rises, p0 + 1);
        chk("R7 glitch never confirmed", busy_rises, b0);
        chk("R7 glitch leaves flags", {rx_ready, rx_overrun, rx_frame_err}, 0);
        chk("R7 glitch leaves data", rx_data, 8'hC7);

        // stop bit low (parity bit 0, so no falling edge into the stop bit)
        send_char(8'h33, 1'b0, P, 1'b0); hold(P);
        chk("R9 low stop bit flags error", rx_frame_err, 1);
        chk("R9 byte still delivered", rx_data, 8'h33);
        pulse_ack(); hold(2);

        // early start: one cycle short of the tolerated limit
        a = 8'h6E; b = 8'h81;
        fork
            begin send_char(a, 1'b0, P - Q - 1, 1'b1); send_char(b, 1'b0, P, 1'b1); end
            begin wait (rx_ready); hold(1); pulse_ack(); end
        join
        hold(30);
        chk("R11 early start flagged", rx_frame_err, 1);
        chk("R11 early start character received", rx_data, b);
        pulse_ack(); hold(10);

        // tolerated early start: exactly at the limit
        b0 = busy_rises;
        a = 8'h17; b = 8'hE4;
        fork
            begin send_char(a, 1'b0, P - Q, 1'b1); send_char(b, 1'b0, P, 1'b1); end
            begin wait (rx_ready); hold(1); pulse_ack(); end
        join
        hold(30);
        chk("R11 tolerated start no error", {rx_frame_err, rx_overrun}, 0);
        chk("R11 tolerated start data", rx_data, b);
        chk("R11 tolerated start latency", rdy_lat, exp_lat());
        chk("R11 busy dropped between characters", busy_rises, b0 + 2);
        pulse_ack(); hold(5);

        // reset in the middle of a character
        line_in = 1'b0; hold(3 * P);
        rst_n = 1'b0; line_in = 1'b1; hold(1);
        chk("R12 reset mid character", {rx_data, rx_ready, rx_overrun, rx_frame_err, start_pend, busy}, 0);
        rst_n = 1'b1; hold(5);
        send_char(8'h42, 1'b0, P, 1'b1); hold(4);
        chk("R1 divider honoured after reset", rdy_lat, exp_lat());
        chk("R8 pending and busy exclusive", both_high, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule